// File: doc/BRIEF.md
# Multi-channel down-counting timer

The block is a memory-mapped timer peripheral on a simple 32-bit register bus. It contains three reloadable down-counters and one 40-bit free-running up-counter. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each down-counter has four registers: a load value, a live count, a control word and an interrupt clear. Each one advances on one of two externally generated tick strobes, which its control word selects.

When a down-counter steps past zero, it raises a level interrupt. It then either reloads from its load register or wraps to its all-ones value. The interrupt stays high until software writes any value to that channel's clear register. The free-running counter cannot interrupt. It advances on a third strobe while its enable bit is set, and it is read as a low word and a high word.

The bus is a single-cycle write strobe with a combinational read path. Reads have no side effects. Tick generation, bus bridging and interrupt routing all sit outside the block.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads zero and all three interrupt lines are low.
- R2: A control write that sets the enable bit (bit 7) while the channel is disabled copies the load register into the counter. The copied value reads back at once from the value register.
- R3: An enabled channel decrements by one on each selected tick. Control bit 3 set selects the fast strobe and clear selects the slow strobe. Pulses on the strobe that is not selected leave the count unchanged.
- R4: In periodic mode (control bit 6 set), a load value of N gives an underflow every N+1 ticks. On underflow the counter reloads with the load value.
- R5: In free-running mode (control bit 6 clear), the tick taken at zero wraps the counter to all ones at the channel's width: 0xFFFF for channels 0 and 1, and 0xFFFFFFFF for channel 2.
- R6: Underflow drives that channel's interrupt line (irq bit equal to the channel index) high. The line stays high until a write of any data to the channel's clear register. An underflow in the same cycle as a clear keeps the line high.
- R7: A load write while the channel runs does not change the current count. The new value is used at the next reload.
- R8: Writes to a value register are ignored. Writes to the free counter's low word are ignored.
- R9: Unused bits read zero. A control register reads back only bits 7, 6 and 3, a 16-bit count is zero above bit 15, and unmapped offsets read zero.
- R10: The free counter's 40-bit value reads as bits 31:0 at offset 0x60. Offset 0x64 returns bits 39:32 in its bits 7:0 and the enable in bit 8. Writing bit 8 sets or clears the enable. While enabled, the counter adds one per free-strobe pulse; while disabled it holds its value.
- R11: A disabled channel holds its count and raises no interrupt, whatever the strobes do.
- R12: Channel bases are 0x00, 0x20 and 0x80. Within a channel, the load register is at +0x0, the value register at +0x4, the control register at +0x8 and the clear register at +0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle slow count strobe |
| fast_tick | input | 1 | One-cycle fast count strobe |
| free_tick | input | 1 | One-cycle strobe for the free-running counter |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Level interrupt, one bit per down-counter |

## Verification
A count held in a channel shows at the value register in the same cycle, because reads are combinational. A wrong decrement, reload or wrap therefore appears at the next read after the faulty tick. Errors in the reload path are slower to surface: they show up as an interrupt that arrives one or more ticks early or late, so the bench counts ticks up to the underflow edge exactly. A stuck pending flag only becomes visible once a clear write fails to drop the line, or a later underflow finds it already high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH  = 3;
  localparam int BUS_W   = 32;
  localparam int FREE_W  = 40;

  // control word bit positions
  localparam int BIT_EN   = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_CSEL = 3;
  localparam int FREE_EN_BIT = 8;

  // register offsets inside a channel window
  localparam logic [7:0] OFS_LOAD = 8'h00;
  localparam logic [7:0] OFS_VAL  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_CLR  = 8'h0C;
  localparam logic [7:0] FREE_LO  = 8'h60;
  localparam logic [7:0] FREE_HI  = 8'h64;

  function automatic logic [7:0] chan_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic int chan_width(input int idx);
    return (idx == 2) ? 32 : 16;
  endfunction

  // next count of a down-counter on a tick
  function automatic logic [31:0] down_next(input logic [31:0] cur,
                                            input logic [31:0] rld,
                                            input logic [31:0] ones,
                                            input logic        periodic);
    if (cur == 32'd0) return periodic ? rld : ones;
    return cur - 32'd1;
  endfunction
endpackage

// File: rtl/tmr_down_chan.sv
module tmr_down_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_tick,
  input  logic         fast_tick,
  input  logic         wr_load,
  input  logic         wr_ctrl,
  input  logic         wr_clr,
  input  logic [W-1:0] load_in,
  input  logic         en_in,
  input  logic         mode_in,
  input  logic         csel_in,
  output logic [31:0]  load_o,
  output logic [31:0]  cnt_o,
  output logic [31:0]  ctrl_o,
  output logic         periodic_o,
  output logic         irq_o,
  output logic         wrap_o
);
  localparam logic [31:0] ONES = 32'((64'd1 << W) - 64'd1);

  logic [W-1:0] load_q, cnt_q;
  logic en_q, mode_q, csel_q, irq_q;
  logic step, start;

  assign step   = en_q & (csel_q ? fast_tick : slow_tick);
  assign start  = wr_ctrl & en_in & ~en_q;
  assign wrap_o = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      csel_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= load_in;
      if (wr_ctrl) begin
        en_q   <= en_in;
        mode_q <= mode_in;
        csel_q <= csel_in;
      end
      if (start)
        cnt_q <= load_q;
      else if (step)
        cnt_q <= W'(down_next(32'(cnt_q), 32'(load_q), ONES, mode_q));
      if (wrap_o)
        irq_q <= 1'b1;
      else if (wr_clr)
        irq_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[BIT_EN]   = en_q;
    ctrl_o[BIT_MODE] = mode_q;
    ctrl_o[BIT_CSEL] = csel_q;
  end

  assign load_o     = 32'(load_q);
  assign cnt_o      = 32'(cnt_q);
  assign periodic_o = mode_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt
  import tmr_pkg::*;
#(
  parameter int W = FREE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_hi,
  input  logic         en_in,
  output logic [31:0]  lo_o,
  output logic [31:0]  hi_o,
  output logic [W-1:0] val_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;
  logic en_q;

  assign step_o = en_q & tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_hi)  en_q  <= en_in;
      if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    hi_o              = '0;
    hi_o[W-33:0]      = cnt_q[W-1:32];
    hi_o[FREE_EN_BIT] = en_q;
  end

  assign lo_o  = cnt_q[31:0];
  assign val_o = cnt_q;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        fast_tick,
  input  logic        free_tick,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [2:0]  irq
);
  // event wires exposed for the bound checker
  logic [NUM_CH-1:0]        wrap_v, clr_v, periodic_v;
  logic [NUM_CH-1:0][31:0]  load_v, cnt_v, ctrl_v;
  logic [FREE_W-1:0]        free_val;
  logic                     free_step;
  logic [31:0]              free_lo, free_hi;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    localparam int         CW   = chan_width(gi);
    localparam logic [7:0] BASE = chan_base(gi);

    logic hit_load, hit_ctrl, hit_clr;
    assign hit_load = bus_wr && (bus_addr == (BASE | OFS_LOAD));
    assign hit_ctrl = bus_wr && (bus_addr == (BASE | OFS_CTRL));
    assign hit_clr  = bus_wr && (bus_addr == (BASE | OFS_CLR));
    assign clr_v[gi] = hit_clr;

    tmr_down_chan #(.W(CW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_tick  (slow_tick),
      .fast_tick  (fast_tick),
      .wr_load    (hit_load),
      .wr_ctrl    (hit_ctrl),
      .wr_clr     (hit_clr),
      .load_in    (bus_wdata[CW-1:0]),
      .en_in      (bus_wdata[BIT_EN]),
      .mode_in    (bus_wdata[BIT_MODE]),
      .csel_in    (bus_wdata[BIT_CSEL]),
      .load_o     (load_v[gi]),
      .cnt_o      (cnt_v[gi]),
      .ctrl_o     (ctrl_v[gi]),
      .periodic_o (periodic_v[gi]),
      .irq_o      (irq[gi]),
      .wrap_o     (wrap_v[gi])
    );
  end

  tmr_free_cnt #(.W(FREE_W)) u_free (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (free_tick),
    .wr_hi  (bus_wr && (bus_addr == FREE_HI)),
    .en_in  (bus_wdata[FREE_EN_BIT]),
    .lo_o   (free_lo),
    .hi_o   (free_hi),
    .val_o  (free_val),
    .step_o (free_step)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == FREE_LO) bus_rdata = free_lo;
    if (bus_addr == FREE_HI) bus_rdata = free_hi;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == (chan_base(i) | OFS_LOAD)) bus_rdata = load_v[i];
      if (bus_addr == (chan_base(i) | OFS_VAL))  bus_rdata = cnt_v[i];
      if (bus_addr == (chan_base(i) | OFS_CTRL)) bus_rdata = ctrl_v[i];
    end
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk
  import tmr_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               irq,
  input logic [NUM_CH-1:0]        wrap_v,
  input logic [NUM_CH-1:0]        clr_v,
  input logic [NUM_CH-1:0]        periodic_v,
  input logic [NUM_CH-1:0][31:0]  load_v,
  input logic [NUM_CH-1:0][31:0]  cnt_v,
  input logic [FREE_W-1:0]        free_val,
  input logic                     free_step
);
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_a
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[gi] |=> irq[gi]);
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[gi] && !clr_v[gi]) |=> irq[gi]);
    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[gi] && !wrap_v[gi]) |=> !irq[gi]);
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[gi]) |-> $past(wrap_v[gi]));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_v[gi] && periodic_v[gi]) |=> cnt_v[gi] == $past(load_v[gi]));
  end

  p_free_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    free_step |=> free_val == $past(free_val) + 40'd1);
  p_free_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !free_step |=> $stable(free_val));
endmodule

bind tick_timer_bank tick_timer_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .wrap_v     (wrap_v),
  .clr_v      (clr_v),
  .periodic_v (periodic_v),
  .load_v     (load_v),
  .cnt_v      (cnt_v),
  .free_val   (free_val),
  .free_step  (free_step)
);

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, fast_tick = 1'b0, free_tick = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  sample_ev;

  always #4 clk = ~clk;

  tick_timer_bank u_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .free_tick(free_tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (sb_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {29'd0, irq} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // which: 0 slow, 1 fast, 2 free
  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (which)
        0: slow_tick = 1'b1;
        1: fast_tick = 1'b1;
        default: free_tick = 1'b1;
      endcase
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0; free_tick = 1'b0;
    end
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> sample_ev;
    #2;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {29'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> sample_ev;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(8'h00, 32'h0, "R1 load0");
    chk_rd(8'h04, 32'h0, "R1 value0");
    chk_rd(8'h08, 32'h0, "R1 ctrl0");
    chk_rd(8'h60, 32'h0, "R1 free lo");
    chk_rd(8'h64, 32'h0, "R1 free hi");
    chk_irq(3'b000, "R1 irq");

    // R12 / R2: load then enable, periodic, slow strobe
    wr(8'h00, 32'd5);
    chk_rd(8'h00, 32'd5, "R12 load offset");
    chk_rd(8'h04, 32'd0, "R2 no copy before enable");
    wr(8'h08, 32'h0000_00C0);
    chk_rd(8'h04, 32'd5, "R2 copy on enable");
    chk_rd(8'h08, 32'h0000_00C0, "R12 ctrl offset");

    // R3 strobe select
    pulse(1, 3);
    chk_rd(8'h04, 32'd5, "R3 fast ignored");
    pulse(0, 2);
    chk_rd(8'h04, 32'd3, "R3 slow decrement");

    // R8 value write ignored
    wr(8'h04, 32'h0000_1234);
    chk_rd(8'h04, 32'd3, "R8 value write");

    // R4 / R7 period and late load
    pulse(0, 3);
    chk_rd(8'h04, 32'd0, "R4 at zero");
    chk_irq(3'b000, "R4 no irq before N+1");
    wr(8'h00, 32'd9);
    chk_rd(8'h04, 32'd0, "R7 count untouched");
    pulse(0, 1);
    chk_rd(8'h04, 32'd9, "R7 reload uses new load");
    chk_irq(3'b001, "R4 irq at tick N+1");

    // R6 level held until clear
    pulse(0, 2);
    chk_rd(8'h04, 32'd7, "R4 counting after reload");
    chk_irq(3'b001, "R6 irq held");
    wr(8'h0C, 32'hDEAD_BEEF);
    chk_irq(3'b000, "R6 clear any value");

    // R11 disabled channel
    wr(8'h08, 32'h0000_0040);
    pulse(0, 3);
    chk_rd(8'h04, 32'd7, "R11 hold when disabled");
    chk_irq(3'b000, "R11 no irq when disabled");

    // R5 free-running wrap, 16 bit on fast strobe
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h0000_0088);
    chk_rd(8'h24, 32'd1, "R12 ch1 value offset");
    pulse(1, 2);
    chk_rd(8'h24, 32'h0000_FFFF, "R5 wrap 16 bit");
    chk_irq(3'b010, "R6 ch1 irq");

    // R5 free-running wrap, 32 bit
    wr(8'h80, 32'd0);
    wr(8'h88, 32'h0000_0080);
    chk_rd(8'h84, 32'd0, "R12 ch2 value offset");
    pulse(0, 1);
    chk_rd(8'h84, 32'hFFFF_FFFF, "R5 wrap 32 bit");
    chk_rd(8'h24, 32'h0000_FFFF, "R3 ch1 ignores slow");
    chk_irq(3'b110, "R6 ch2 irq");

    // R9 unused bits
    wr(8'h08, 32'hFFFF_FFFF);
    chk_rd(8'h08, 32'h0000_00C8, "R9 ctrl bits only");
    chk_rd(8'h04, 32'd9, "R2 re-enable copies load");
    chk_rd(8'h40, 32'h0, "R9 unmapped");
    wr(8'h08, 32'h0);
    wr(8'h2C, 32'h0);
    wr(8'h8C, 32'h1);
    chk_irq(3'b000, "R6 clear ch1 ch2");

    // R10 free counter
    pulse(2, 3);
    chk_rd(8'h60, 32'h0, "R10 disabled holds");
    wr(8'h64, 32'h0000_0100);
    chk_rd(8'h64, 32'h0000_0100, "R10 enable bit");
    pulse(2, 4);
    chk_rd(8'h60, 32'd4, "R10 counts");
    wr(8'h60, 32'h55);
    chk_rd(8'h60, 32'd4, "R8 free lo write");
    wr(8'h64, 32'h0);
    pulse(2, 2);
    chk_rd(8'h60, 32'd4, "R10 stop holds");
    chk_rd(8'h64, 32'h0, "R10 hi after disable");

    @(negedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule